// File: doc/BRIEF.md
# Unrolled Five-Point Stencil Stream Engine

This block takes a 2-D tile of pixels that arrives in row-major order and computes, for every pixel, the average of that pixel and its four orthogonal neighbours. Each handshake beat carries `LANES` consecutive pixels. Each beat of results carries `LANES` averaged pixels, so the engine keeps pace with an input stream that is `LANES` pixels wide. The row width is a parameter. The number of rows is unbounded, because only the row width sets the buffer size.

Every lane has its own delay chain. Together the chains form a reuse window of just over two rows. The five taps for each result are picked from that window at linearised distances of 0, W-1, W, W+1 and 2W pixels from the newest neighbour. One averaging element is instantiated per lane. A single registered output stage sits behind a valid/ready handshake. A stall at the output freezes every chain at once, so the lanes never drift out of alignment.

Top module: `stencil5_stream`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1. Reset also clears the fill count, so the rule in R4 applies again from the first beat accepted after reset.
- R2: Each result equals floor((N+S+E+W+C) * 13107 + 32768) / 65536. This is the sum multiplied by a 16-bit rounded reciprocal of five, with rounding to nearest.
- R3: Input lane k of accepted beat b (counted from 0 since reset) is the pixel at stream position b*LANES+k, in bits [k*PIX_W +: PIX_W]. Output lane k of the result for beat b is centred on position c = b*LANES+k-ROW_W. It uses the pixels at c-ROW_W (north), c-1, c, c+1 and c+ROW_W (south).
- R4: No result is produced for the first NB-1 accepted beats, where NB = floor((2*ROW_W+LANES-1)/LANES)+1. Beat NB-1 yields the first result. Every later beat yields exactly one result.
- R5: A result appears on `out_valid`/`out_data` in the cycle after the accepting clock edge of the beat that completes it.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` and `out_valid` hold their values. No input beat and no result is lost.
- R7: With `out_ready` held at 1, `in_ready` stays at 1, and one beat is accepted and one result is emitted every cycle.
- R8: Centres in the first or last column of a row are still emitted. Their east or west tap is the linearised neighbour from the adjacent row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | LANES*PIX_W | Consecutive pixels, lane 0 earliest |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_data | output | LANES*PIX_W | Averaged pixels, lane k centred per R3 |

## Verification
The embedded properties assume that `out_ready` is a plain input, free to drop at any cycle, and that `in_valid` is never qualified by `in_ready`. They also assume that pixel values are full-range unsigned numbers. The bench respects all of this. It drives inputs on the falling edge only. It offers beats continuously, whatever the ready state. It throttles `out_ready` in periodic patterns. Its pixel patterns include all-ones, so the averaging bounds are exercised at the top of the range.

// File: rtl/stencil5_pkg.sv
package stencil5_pkg;

  // Reciprocal of five in 16 fractional bits, rounded to nearest.
  localparam int unsigned RECIP_FRAC = 16;
  localparam logic [31:0] RECIP5     = 32'd13107;
  localparam logic [63:0] HALF_LSB   = 64'd32768;

  // Scale a five-pixel sum by one fifth, rounding to nearest.
  function automatic logic [31:0] scale_fifth(input logic [31:0] sum);
    logic [63:0] prod;
    prod = {32'd0, sum} * {32'd0, RECIP5} + HALF_LSB;
    return prod[RECIP_FRAC +: 32];
  endfunction

  // Map a pixel age (0 = newest) to its flat slot index in the window.
  // The window is stored as beat-major, lane-minor. The newest pixel is
  // lane LANES-1 of beat 0.
  function automatic int age_slot(input int age, input int lanes);
    return (age / lanes) * lanes + (lanes - 1 - (age % lanes));
  endfunction

endpackage

// File: rtl/s5_lane_chain.sv
module s5_lane_chain #(
  parameter int PIX_W = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift_en,
  input  logic [PIX_W-1:0]           din,
  output logic [(DEPTH+1)*PIX_W-1:0] view
);

  logic [PIX_W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else if (shift_en) begin
      stage[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  // The view exposes the window as it will be after the next shift:
  // slot 0 is the incoming pixel, and slot i is stage i-1.
  assign view[0 +: PIX_W] = din;
  for (genvar g = 0; g < DEPTH; g++) begin : g_view
    assign view[(g+1)*PIX_W +: PIX_W] = stage[g];
  end

  AST_CHAIN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stage[0] == $past(din)); // R3
  AST_CHAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stage[DEPTH-1])); // R6

endmodule

// File: rtl/s5_reuse_buffer.sv
module s5_reuse_buffer #(
  parameter int PIX_W = 16,
  parameter int LANES = 2,
  parameter int NB    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift_en,
  input  logic [LANES*PIX_W-1:0]      din,
  output logic [NB*LANES*PIX_W-1:0]   window
);

  localparam int DEPTH = NB - 1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [NB*PIX_W-1:0] lane_view;

    s5_lane_chain #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (din[k*PIX_W +: PIX_W]),
      .view     (lane_view)
    );

    for (genvar b = 0; b < NB; b++) begin : g_slot
      assign window[(b*LANES + k)*PIX_W +: PIX_W] = lane_view[b*PIX_W +: PIX_W];
    end
  end

endmodule

// File: rtl/s5_pe.sv
module s5_pe
  import stencil5_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] tap_n,
  input  logic [PIX_W-1:0] tap_w,
  input  logic [PIX_W-1:0] tap_c,
  input  logic [PIX_W-1:0] tap_e,
  input  logic [PIX_W-1:0] tap_s,
  output logic [PIX_W-1:0] result
);

  logic [31:0]      sum5;
  logic [31:0]      scaled;
  logic [PIX_W-1:0] hi01, hi23, hi_all, lo01, lo23, lo_all;

  always_comb begin
    sum5   = 32'(tap_n) + 32'(tap_w) + 32'(tap_c) + 32'(tap_e) + 32'(tap_s);
    scaled = scale_fifth(sum5);
    result = scaled[PIX_W-1:0];
  end

  // Extremes of the five taps, used only to bound the average.
  always_comb begin
    hi01   = (tap_n > tap_w) ? tap_n : tap_w;
    hi23   = (tap_c > tap_e) ? tap_c : tap_e;
    hi_all = (hi01 > hi23) ? hi01 : hi23;
    hi_all = (hi_all > tap_s) ? hi_all : tap_s;
    lo01   = (tap_n < tap_w) ? tap_n : tap_w;
    lo23   = (tap_c < tap_e) ? tap_c : tap_e;
    lo_all = (lo01 < lo23) ? lo01 : lo23;
    lo_all = (lo_all < tap_s) ? lo_all : tap_s;
  end

  AST_AVG_NOT_ABOVE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    result <= hi_all); // R2
  AST_AVG_NEAR_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (33'(result) + 33'd1) >= 33'(lo_all)); // R2

endmodule

// File: rtl/s5_flow.sv
module s5_flow #(
  parameter int FILL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic accept,
  output logic out_valid
);

  localparam int CW = $clog2(FILL + 1);

  logic [CW-1:0] fill_cnt;
  logic          window_full;

  assign window_full = (fill_cnt == CW'(FILL));
  assign in_ready    = !out_valid || out_ready;
  assign accept      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (accept && !window_full) fill_cnt <= fill_cnt + CW'(1);
      if (accept)         out_valid <= window_full;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid); // R6
  AST_RESULT_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid)); // R5
  AST_NO_RESULT_UNFILLED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !window_full |=> !out_valid); // R4

endmodule

// File: rtl/stencil5_stream.sv
module stencil5_stream
  import stencil5_pkg::*;
#(
  parameter int PIX_W = 16,
  parameter int ROW_W = 2000,
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*PIX_W-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*PIX_W-1:0] out_data
);

  // Window span in pixels and in beats.
  localparam int SPAN = 2 * ROW_W + LANES;
  localparam int NB   = (SPAN - 1) / LANES + 1;

  logic                        accept;
  logic [NB*LANES*PIX_W-1:0]   window;
  logic [LANES*PIX_W-1:0]      pe_out;

  s5_flow #(.FILL(NB - 1)) u_flow (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .accept    (accept),
    .out_valid (out_valid)
  );

  s5_reuse_buffer #(.PIX_W(PIX_W), .LANES(LANES), .NB(NB)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .din      (in_data),
    .window   (window)
  );

  // Output lane k: its south tap is the pixel of age LANES-1-k.
  for (genvar k = 0; k < LANES; k++) begin : g_pe
    localparam int AGE_S = LANES - 1 - k;
    localparam int AGE_E = AGE_S + ROW_W - 1;
    localparam int AGE_C = AGE_S + ROW_W;
    localparam int AGE_W = AGE_S + ROW_W + 1;
    localparam int AGE_N = AGE_S + 2 * ROW_W;

    s5_pe #(.PIX_W(PIX_W)) u_pe (
      .clk    (clk),
      .rst_n  (rst_n),
      .tap_n  (window[age_slot(AGE_N, LANES)*PIX_W +: PIX_W]),
      .tap_w  (window[age_slot(AGE_W, LANES)*PIX_W +: PIX_W]),
      .tap_c  (window[age_slot(AGE_C, LANES)*PIX_W +: PIX_W]),
      .tap_e  (window[age_slot(AGE_E, LANES)*PIX_W +: PIX_W]),
      .tap_s  (window[age_slot(AGE_S, LANES)*PIX_W +: PIX_W]),
      .result (pe_out[k*PIX_W +: PIX_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      out_data <= '0;
    else if (accept) out_data <= pe_out;
  end

  AST_DATA_HELD_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data)); // R6

endmodule

// File: tb/stencil5_stream_tb.sv
module stencil5_stream_tb;

  localparam int PW   = 16;
  localparam int W    = 12;
  localparam int L    = 2;
  localparam int NB   = (2 * W + L - 1) / L + 1;
  localparam int ROWS = 6;
  localparam int TOT  = ROWS * W / L;

  // Each phase: {pixel pattern, out_ready stall period (0 = never)}.
  localparam int NVEC = 5;
  localparam int VEC [NVEC][2] = '{'{0, 0}, '{1, 3}, '{2, 0}, '{3, 2}, '{1, 5}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [L*PW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [L*PW-1:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  stencil5_stream #(.PIX_W(PW), .ROW_W(W), .LANES(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [15:0] pix(input int pat, input int s);
    int v;
    case (pat)
      0:       v = s * 7 + 3;
      1:       v = (s * 40503 + 12345) ^ (s * 311);
      2:       v = 65535;
      default: v = ((s / W) % 2 == 1) ? 65535 : (s % 5) * 1000;
    endcase
    return v[15:0];
  endfunction

  // Average rule of R2, written in integer arithmetic.
  function automatic logic [15:0] expect_px(input int pat, input int c);
    longint sum, q;
    sum = longint'(pix(pat, c - W)) + longint'(pix(pat, c - 1)) + longint'(pix(pat, c))
        + longint'(pix(pat, c + 1)) + longint'(pix(pat, c + W));
    q = (sum * 13107 + 32768) / 65536;
    return q[15:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_phase(input int pat, input int per);
    int beat = 0, outs = 0, last_acc = -1, cyc = 0;
    bit held = 1'b0;
    logic [L*PW-1:0] held_data = '0;
    bit acc;
    do_reset();
    while ((beat < TOT || outs < TOT - (NB - 1)) && cyc < 400) begin
      out_ready = (per == 0) ? 1'b1 : ((cyc % per) != 0);
      #1;
      if (held) begin  // R6: held result survives the stall
        check(out_valid === 1'b1, "R6 valid held", longint'(out_valid), 1);
        check(out_data === held_data, "R6 data held", longint'(out_data), longint'(held_data));
      end
      if (last_acc >= 0)  // R4/R5: result exactly one cycle after the completing beat
        check(out_valid === (last_acc >= NB - 1), "R4/R5 latency", longint'(out_valid),
              longint'(last_acc >= NB - 1));
      held = 1'b0;
      if (out_valid === 1'b1) begin
        if (out_ready) begin
          for (int k = 0; k < L; k++) begin
            int c = (NB - 1 + outs) * L + k - W;
            logic [15:0] e = expect_px(pat, c);
            logic [15:0] a = out_data[k*PW +: PW];
            if (c % W == 0 || c % W == W - 1)
              check(a === e, "R8 edge column", a, e);
            else
              check(a === e, "R2/R3 average", a, e);
          end
          outs++;
        end else begin
          held = 1'b1; held_data = out_data;
          check(in_ready === 1'b0, "R6 in_ready low", longint'(in_ready), 0);
        end
      end
      if (per == 0 && beat < TOT)
        check(in_ready === 1'b1, "R7 full rate", longint'(in_ready), 1);
      acc = 1'b0;
      if (beat < TOT) begin
        in_valid = 1'b1;
        for (int k = 0; k < L; k++) in_data[k*PW +: PW] = pix(pat, beat * L + k);
        acc = in_ready;
      end else begin
        in_valid = 1'b0;
      end
      last_acc = acc ? beat : -1;
      if (acc) beat++;
      cyc++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(outs == TOT - (NB - 1), "R4 result count", outs, TOT - (NB - 1));
  endtask

  initial begin
    // R1: state during and right after reset
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    check(in_ready === 1'b1, "R1 in_ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);

    for (int v = 0; v < NVEC; v++) run_phase(VEC[v][0], VEC[v][1]);

    // R1: reset while a result is stalled clears it
    do_reset();
    out_ready = 1'b0;
    for (int b = 0; b < NB + 1; b++) begin
      in_valid = 1'b1;
      in_data = {pix(1, 2 * b + 1), pix(1, 2 * b)};
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R6 stalled result present", longint'(out_valid), 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    check(out_valid === 1'b0, "R1 reset drops result", longint'(out_valid), 0);
    check(in_ready === 1'b1, "R1 reset reopens input", longint'(in_ready), 1);
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", n, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule